// File: doc/BRIEF.md
# Logical-to-Physical Floppy Drive Remapper

This block sits between a host register interface and a floppy controller core. The host picks a logical drive (0 to 3) through a drive-select register. The block turns that into a physical drive number through a four-entry table that software can reprogram. One bit of the drive-select register bypasses the table, so the low two select bits are passed straight through. The same control register that loads the table also sets the density mode for every drive: 2D or 2DD.

The block also adjusts track numbers written by the host before they reach the controller. Each physical drive reports through an input whether its inserted media is double-density. When that media sits in a drive running in 2D mode, the track value is doubled, because the head must step twice per logical track. The control register and a drive-status byte can be read back combinationally.

Top module: `drv_remap`

## Requirements
- R1: After reset, the table holds the identity mapping (logical n gives physical n), the control register reads back 0xA0, `dens_2d` is 1, the drive-select register is 0x00 (table mode, logical drive 0), `stat_rdata` is 0x3C, `trk_out` is 0x00 and `trk_load` is 0.
- R2: A control write with bit 4 set loads table entry number `ctl_wdata[3:2]` with `ctl_wdata[1:0]`. A control write with bit 4 clear leaves every table entry unchanged.
- R3: When a control write updates the table entry of the logical drive currently selected in table mode, `phys_drv` shows the new value in the cycle after the write.
- R4: When drive-select bit 6 is 0, `phys_drv` is the table entry indexed by select bits 1:0. When bit 6 is 1, `phys_drv` equals select bits 1:0.
- R5: Every control write sets `dens_2d` to `ctl_wdata[6]` (1 means 2D for all drives, 0 means 2DD) from the next cycle on.
- R6: `ctl_rdata` is 0xA0 OR (stored control byte AND 0x5F). A control write stores the whole byte.
- R7: `stat_rdata` is {0, select bit 6, 4'b1111, select bits 1:0}.
- R8: A track write drives `trk_out` in the next cycle. The value is `trk_wdata` shifted left by one and truncated to 8 bits when `media_dd[phys_drv]` is 1 and `dens_2d` is 1. Otherwise it is `trk_wdata` unchanged. `trk_load` is high for exactly that one cycle.
- R9: Without a track write, `trk_out` keeps its value, even when the selection, the density or `media_dd` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_wr | input | 1 | Drive-select register write strobe |
| sel_wdata | input | 8 | Drive-select data: bit 6 bypasses the table, bits 1:0 give the logical drive |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control data: bit 6 density, bit 4 table load, bits 3:2 entry, bits 1:0 value |
| trk_wr | input | 1 | Track write strobe |
| trk_wdata | input | 8 | Track number from the host |
| media_dd | input | 4 | Per physical drive: 1 when the inserted media is double-density |
| phys_drv | output | 2 | Physical drive number for the controller |
| dens_2d | output | 1 | 1 for 2D mode, 0 for 2DD mode |
| ctl_rdata | output | 8 | Control register readback |
| stat_rdata | output | 8 | Drive-select status readback |
| trk_out | output | 8 | Adjusted track number |
| trk_load | output | 1 | One-cycle pulse when `trk_out` takes a new value |

## Verification
All register state updates on the clock edge that samples a write strobe. `phys_drv`, `dens_2d`, `ctl_rdata` and `stat_rdata` are combinational from that state, so they are due one cycle after the strobe. `trk_out` and `trk_load` each pass through one register and are also due one cycle after `trk_wr`; `trk_load` drops again a cycle later. The bench drives every strobe on a falling edge and lowers it on the next falling edge, then samples there, half a period after the edge that took the write. The hold checks sample one more falling edge later, after unrelated inputs have changed.

// File: rtl/drv_remap_pkg.sv
package drv_remap_pkg;
  localparam int unsigned DRV_NUM   = 4;
  localparam int unsigned DRV_W     = $clog2(DRV_NUM);
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned TRK_W     = 8;

  // control register fields
  localparam int unsigned CTL_DENS_BIT = 6;
  localparam int unsigned CTL_LOAD_BIT = 4;
  localparam int unsigned CTL_IDX_LSB  = 2;
  localparam int unsigned CTL_VAL_LSB  = 0;
  localparam logic [BYTE_W-1:0] CTL_RST     = 8'h80;
  localparam logic [BYTE_W-1:0] CTL_RD_SET  = 8'hA0;
  localparam logic [BYTE_W-1:0] CTL_RD_MASK = 8'h5F;

  // drive select register fields
  localparam int unsigned SEL_BYP_BIT = 6;

  typedef logic [DRV_W-1:0] drv_t;
endpackage

// File: rtl/drv_map_table.sv
module drv_map_table
  import drv_remap_pkg::*;
#(
  parameter int unsigned N = DRV_NUM
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           we,
  input  drv_t           wr_idx,
  input  drv_t           wr_val,
  input  drv_t           rd_idx,
  output drv_t           rd_val
);
  drv_t tab_q [N];
  drv_t tab_d [N];

  for (genvar g = 0; g < N; g++) begin : g_ent
    always_comb begin
      tab_d[g] = tab_q[g];
      if (we && (wr_idx == drv_t'(g))) tab_d[g] = wr_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tab_q[g] <= drv_t'(g);
      else        tab_q[g] <= tab_d[g];
    end
  end

  assign rd_val = tab_q[rd_idx];

  // R2
  table_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> tab_q[$past(wr_idx)] == $past(wr_val));

  // R2
  table_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> tab_q[rd_idx] == $past(tab_q[rd_idx]) || rd_idx != $past(rd_idx));
endmodule

// File: rtl/drv_host_regs.sv
module drv_host_regs
  import drv_remap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_wr,
  input  logic [BYTE_W-1:0] sel_wdata,
  input  logic              ctl_wr,
  input  logic [BYTE_W-1:0] ctl_wdata,
  output logic              byp_q,
  output drv_t              lsel_q,
  output logic              dens_q,
  output logic              tab_we,
  output drv_t              tab_idx,
  output drv_t              tab_val,
  output logic [BYTE_W-1:0] ctl_rdata,
  output logic [BYTE_W-1:0] stat_rdata
);
  logic [BYTE_W-1:0] ctl_q, ctl_d;
  logic              byp_d, dens_d;
  drv_t              lsel_d;

  always_comb begin
    ctl_d  = ctl_q;
    dens_d = dens_q;
    byp_d  = byp_q;
    lsel_d = lsel_q;
    if (ctl_wr) begin
      ctl_d  = ctl_wdata;
      dens_d = ctl_wdata[CTL_DENS_BIT];
    end
    if (sel_wr) begin
      byp_d  = sel_wdata[SEL_BYP_BIT];
      lsel_d = sel_wdata[DRV_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= CTL_RST;
      dens_q <= 1'b1;
      byp_q  <= 1'b0;
      lsel_q <= '0;
    end else begin
      ctl_q  <= ctl_d;
      dens_q <= dens_d;
      byp_q  <= byp_d;
      lsel_q <= lsel_d;
    end
  end

  assign tab_we  = ctl_wr && ctl_wdata[CTL_LOAD_BIT];
  assign tab_idx = ctl_wdata[CTL_IDX_LSB +: DRV_W];
  assign tab_val = ctl_wdata[CTL_VAL_LSB +: DRV_W];

  assign ctl_rdata  = CTL_RD_SET | (ctl_q & CTL_RD_MASK);
  assign stat_rdata = {1'b0, byp_q, 4'b1111, lsel_q};

  // R5
  dens_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> dens_q == $past(ctl_wdata[CTL_DENS_BIT]));

  // R6
  ctl_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> ctl_rdata == (CTL_RD_SET | ($past(ctl_wdata) & CTL_RD_MASK)));

  // R7
  stat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_wr |=> $stable(stat_rdata));
endmodule

// File: rtl/trk_adjust.sv
module trk_adjust
  import drv_remap_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               trk_wr,
  input  logic [TRK_W-1:0]   trk_wdata,
  input  logic [DRV_NUM-1:0] media_dd,
  input  drv_t               phys,
  input  logic               dens_2d,
  output logic [TRK_W-1:0]   trk_out,
  output logic               trk_load
);
  logic             dbl;
  logic [TRK_W-1:0] trk_d;

  always_comb begin
    dbl   = media_dd[phys] && dens_2d;
    trk_d = trk_out;
    if (trk_wr) trk_d = dbl ? {trk_wdata[TRK_W-2:0], 1'b0} : trk_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trk_out  <= '0;
      trk_load <= 1'b0;
    end else begin
      trk_out  <= trk_d;
      trk_load <= trk_wr;
    end
  end

  // R8
  trk_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trk_wr |=> trk_load);

  // R8
  trk_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trk_wr && !dens_2d |=> trk_out == $past(trk_wdata));

  // R9
  trk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !trk_wr |=> $stable(trk_out) && !trk_load);
endmodule

// File: rtl/drv_remap.sv
module drv_remap
  import drv_remap_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sel_wr,
  input  logic [BYTE_W-1:0]  sel_wdata,
  input  logic               ctl_wr,
  input  logic [BYTE_W-1:0]  ctl_wdata,
  input  logic               trk_wr,
  input  logic [TRK_W-1:0]   trk_wdata,
  input  logic [DRV_NUM-1:0] media_dd,
  output logic [DRV_W-1:0]   phys_drv,
  output logic               dens_2d,
  output logic [BYTE_W-1:0]  ctl_rdata,
  output logic [BYTE_W-1:0]  stat_rdata,
  output logic [TRK_W-1:0]   trk_out,
  output logic               trk_load
);
  logic byp;
  logic tab_we;
  drv_t lsel, tab_idx, tab_val, tab_phys;

  drv_host_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_wr     (sel_wr),
    .sel_wdata  (sel_wdata),
    .ctl_wr     (ctl_wr),
    .ctl_wdata  (ctl_wdata),
    .byp_q      (byp),
    .lsel_q     (lsel),
    .dens_q     (dens_2d),
    .tab_we     (tab_we),
    .tab_idx    (tab_idx),
    .tab_val    (tab_val),
    .ctl_rdata  (ctl_rdata),
    .stat_rdata (stat_rdata)
  );

  drv_map_table #(.N(DRV_NUM)) u_tab (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (tab_we),
    .wr_idx (tab_idx),
    .wr_val (tab_val),
    .rd_idx (lsel),
    .rd_val (tab_phys)
  );

  assign phys_drv = byp ? lsel : tab_phys;

  trk_adjust u_trk (
    .clk       (clk),
    .rst_n     (rst_n),
    .trk_wr    (trk_wr),
    .trk_wdata (trk_wdata),
    .media_dd  (media_dd),
    .phys      (phys_drv),
    .dens_2d   (dens_2d),
    .trk_out   (trk_out),
    .trk_load  (trk_load)
  );

  // R3
  live_remap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tab_we && !sel_wr && !byp && tab_idx == lsel |=> phys_drv == $past(tab_val));

  // R4
  bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_wr && sel_wdata[SEL_BYP_BIT] |=> phys_drv == $past(sel_wdata[DRV_W-1:0]));
endmodule

// File: tb/drv_remap_tb.sv
module drv_remap_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel_wr = 1'b0, ctl_wr = 1'b0, trk_wr = 1'b0;
  logic [7:0] sel_wdata = '0, ctl_wdata = '0, trk_wdata = '0;
  logic [3:0] media_dd = '0;
  logic [1:0] phys_drv;
  logic       dens_2d, trk_load;
  logic [7:0] ctl_rdata, stat_rdata, trk_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  drv_remap u_dut (
    .clk(clk), .rst_n(rst_n),
    .sel_wr(sel_wr), .sel_wdata(sel_wdata),
    .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .trk_wr(trk_wr), .trk_wdata(trk_wdata),
    .media_dd(media_dd),
    .phys_drv(phys_drv), .dens_2d(dens_2d),
    .ctl_rdata(ctl_rdata), .stat_rdata(stat_rdata),
    .trk_out(trk_out), .trk_load(trk_load)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr_sel(input logic [7:0] v);
    @(negedge clk); sel_wr = 1'b1; sel_wdata = v;
    @(negedge clk); sel_wr = 1'b0;
  endtask

  task automatic wr_ctl(input logic [7:0] v);
    @(negedge clk); ctl_wr = 1'b1; ctl_wdata = v;
    @(negedge clk); ctl_wr = 1'b0;
  endtask

  task automatic wr_trk(input logic [7:0] v);
    @(negedge clk); trk_wr = 1'b1; trk_wdata = v;
    @(negedge clk); trk_wr = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 ctl_rdata", ctl_rdata, 8'hA0);
    check("R1 dens_2d", dens_2d, 1);
    check("R1 stat_rdata", stat_rdata, 8'h3C);
    check("R1 trk_out", trk_out, 0);
    check("R1 trk_load", trk_load, 0);
    for (int i = 0; i < 4; i++) begin
      wr_sel(8'(i));
      check("R1 identity", phys_drv, i);
    end
  endtask

  task automatic t_table;
    // remap entry 2 -> 1, entry 0 -> 3 while logical 3 selected
    wr_sel(8'h03);
    wr_ctl(8'h19);          // R2 entry 2 <= 1
    check("R2 other entry unchanged", phys_drv, 3);
    wr_ctl(8'h13);          // entry 0 <= 3
    wr_sel(8'h02);
    check("R2 entry2 loaded", phys_drv, 1);
    wr_sel(8'h00);
    check("R2 entry0 loaded", phys_drv, 3);
    wr_ctl(8'h0E);          // bit4 clear: no table change
    check("R2 no load without bit4", phys_drv, 3);
    wr_sel(8'h02);
    check("R2 entry2 kept", phys_drv, 1);
    // R3 live update of selected entry
    wr_ctl(8'h1A);          // entry 2 <= 2
    check("R3 live remap", phys_drv, 2);
    wr_ctl(8'h18);          // entry 2 <= 0
    check("R3 live remap again", phys_drv, 0);
  endtask

  task automatic t_bypass;
    wr_sel(8'h42);
    check("R4 bypass phys", phys_drv, 2);
    wr_ctl(8'h19);          // entry 2 <= 1, bypassed
    check("R4 bypass ignores table", phys_drv, 2);
    wr_sel(8'h02);
    check("R4 table mode", phys_drv, 1);
    wr_sel(8'h00);
    check("R4 table entry0", phys_drv, 3);
    wr_sel(8'h40);
    check("R4 bypass drive0", phys_drv, 0);
  endtask

  task automatic t_density_readback;
    wr_ctl(8'h00);
    check("R5 2DD", dens_2d, 0);
    check("R6 readback 00", ctl_rdata, 8'hA0);
    wr_ctl(8'h40);
    check("R5 2D", dens_2d, 1);
    check("R6 readback 40", ctl_rdata, 8'hE0);
    wr_ctl(8'hFF);          // also loads entry 3 <= 3
    check("R6 readback FF", ctl_rdata, 8'hFF);
    wr_ctl(8'h2F);
    check("R6 readback 2F", ctl_rdata, 8'hAF);
    check("R5 2DD again", dens_2d, 0);
  endtask

  task automatic t_status;
    wr_sel(8'h43);
    check("R7 status bypass", stat_rdata, 8'h7F);
    wr_sel(8'hB1);
    check("R7 status plain", stat_rdata, 8'h3D);
  endtask

  task automatic t_track;
    // table: 0->3,1->1,2->1,3->3 ; select bypass drive 1
    wr_ctl(8'h40);          // 2D
    wr_sel(8'h41);
    media_dd = 4'b0010;
    wr_trk(8'h45);
    check("R8 doubled", trk_out, 8'h8A);
    check("R8 load pulse", trk_load, 1);
    @(negedge clk);
    check("R8 pulse ends", trk_load, 0);
    wr_trk(8'h90);
    check("R8 doubled truncated", trk_out, 8'h20);
    media_dd = 4'b1101;
    wr_trk(8'h33);
    check("R8 media 2D no shift", trk_out, 8'h33);
    media_dd = 4'b1111;
    wr_ctl(8'h00);          // 2DD
    wr_trk(8'h21);
    check("R8 2DD no shift", trk_out, 8'h21);
    wr_ctl(8'h40);
    media_dd = 4'b1000;
    wr_sel(8'h00);          // table entry0 -> 3
    wr_trk(8'h11);
    check("R8 via table", trk_out, 8'h22);
  endtask

  task automatic t_hold;
    @(negedge clk);
    trk_wdata = 8'h77; media_dd = 4'b0000;
    wr_ctl(8'h00);
    wr_sel(8'h42);
    @(negedge clk);
    check("R9 hold", trk_out, 8'h22);
    check("R9 no pulse", trk_load, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_table();
    t_bypass();
    t_density_readback();
    t_status();
    t_track();
    t_hold();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=0x0 expected=0x1");
      end
    join_any
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule